// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a byte-wide serial EEPROM on a two-wire (I2C) bus. It samples SCL and SDA with the system clock, finds START, repeated START and STOP conditions, and then runs the usual EEPROM command set. The commands are byte write, page write, current-address read, random read and sequential read. A select byte opens each transfer. It holds a fixed 4-bit prefix, three bits that must equal the `chipSel` pins, and a direction bit. Two address bytes then load an internal address counter. The array depth is a parameter: `ADDR_W` address bits, with 15 bits for a 32K x 8 part and 11 bits by default.

Write data first goes into a page latch. It reaches the array only during a timed internal write cycle. That cycle starts when a STOP arrives directly after the acknowledge slot of an accepted data byte. While the cycle runs, the slave ignores the bus completely. A master can therefore learn when the cycle has ended by repeating START plus select byte until it gets an acknowledge. The `writeLock` input refuses data bytes but leaves reads alone. The slave pulls SDA low through `sdaDrvLow`, and the pad logic outside turns this into an open-drain output.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset `busy` is 0 and `sdaDrvLow` is 0 (SDA released).
- R2: A select byte of the form 1010, then `chipSel[2:0]`, then the direction bit (MSB first, direction 0 = write, 1 = read) is acknowledged. Any other select byte is left unacknowledged, and the bytes after it are ignored until the next START.
- R3: A byte write (select with direction 0, address high byte, address low byte, one data byte, STOP) stores the byte at that address once the write cycle ends.
- R4: A page write uses a 64-byte page. The low 6 address bits advance after each data byte and wrap inside the page. Only the page bytes received before the STOP change, and all other bytes keep their old values.
- R5: The write cycle starts only on a STOP that comes right after the acknowledge slot of an accepted data byte. A STOP inside a data byte, or one straight after the address bytes, starts no cycle and leaves memory unchanged.
- R6: During the write cycle `busy` is 1 for exactly `WRITE_CYCLES` clocks. The slave never drives SDA and leaves its own select byte unacknowledged. After the cycle ends, a START plus a matching select byte is acknowledged.
- R7: A random read (write select, two address bytes, repeated START, read select) returns the byte at the loaded address, MSB first.
- R8: In a read, each byte the master acknowledges advances the address counter by one. The counter wraps from the top address to 0.
- R9: A read byte that the master does not acknowledge ends the output: SDA is released and the counter does not advance, so a following current-address read returns that same byte.
- R10: With `writeLock` at 1, the select byte and address bytes are acknowledged, data bytes are not, no write cycle starts and memory is unchanged. Reads give the same results at either level of `writeLock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad |
| chipSel | input | 3 | Address pins compared with select bits 3..1 |
| writeLock | input | 1 | 1 refuses data bytes of writes |
| sdaDrvLow | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two events can meet in one cycle: the end of the internal write cycle and the master's acknowledge-polling select byte. The bench starts polling right after the committing STOP. The first poll falls inside the busy window and must get no acknowledge, and a later poll must be acknowledged once `busy` has fallen. The length of the busy pulse is measured clock by clock, and the bus is watched on every clock for any drive by the slave while `busy` is high. Reads after the cycle confirm that the committed page bytes landed and their neighbours did not change.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WRITE,
    ST_READ
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadAddrHi;
    logic loadAddrLo;
    logic latchData;
    logic incAddr;
    logic loadTx;
    logic shiftTx;
    logic commitStart;
  } dpCmd_t;

  localparam logic [3:0] SELECT_PREFIX = 4'b1010;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCmd_t       cmd,
  output logic [7:0]   rxByte,
  output logic         txBit
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] LOW_ONE  = 1;
  localparam logic [PAGE_W-1:0] LOW_LAST = PAGE_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [7:0]            rxShift;
  logic [7:0]            txShift;
  logic [HI_W-1:0]       addrHi;
  logic [ADDR_W-1:0]     addrCnt;
  logic [PAGE_BYTES-1:0] pageValid;
  logic                  commitActive;
  logic [PAGE_W-1:0]     commitIdx;
  logic [7:0]            pageData [PAGE_BYTES];
  logic [7:0]            mem      [DEPTH];

  logic [PAGE_W-1:0]     pageIdx;
  assign pageIdx = addrCnt[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift      <= '0;
      txShift      <= '1;
      addrHi       <= '0;
      addrCnt      <= '0;
      pageValid    <= '0;
      commitActive <= 1'b0;
      commitIdx    <= '0;
    end else begin
      if (cmd.shiftIn)    rxShift <= {rxShift[6:0], cmd.rxBit};
      if (cmd.loadAddrHi) addrHi  <= rxShift[HI_W-1:0];
      if (cmd.loadAddrLo) begin
        addrCnt   <= {addrHi, rxShift};
        pageValid <= '0;
      end else if (cmd.latchData) begin
        pageValid[pageIdx] <= 1'b1;
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], pageIdx + LOW_ONE};
      end else if (cmd.incAddr) begin
        addrCnt <= addrCnt + ADDR_ONE;
      end
      if (cmd.loadTx)       txShift <= mem[addrCnt];
      else if (cmd.shiftTx) txShift <= {txShift[6:0], 1'b1};
      if (cmd.commitStart) begin
        commitActive <= 1'b1;
        commitIdx    <= '0;
      end else if (commitActive) begin
        commitIdx <= commitIdx + LOW_ONE;
        if (commitIdx == LOW_LAST) commitActive <= 1'b0;
      end
    end
  end

  // storage without reset: page latch and array
  always_ff @(posedge clk) begin
    if (cmd.latchData) pageData[pageIdx] <= rxShift;
    if (commitActive && pageValid[commitIdx])
      mem[{addrCnt[ADDR_W-1:PAGE_W], commitIdx}] <= pageData[commitIdx];
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  // page writes never leave their page
  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latchData |=> $stable(addrCnt[ADDR_W-1:PAGE_W]));

  // a new write cycle never starts on top of a running copy
  assert_commit_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commitStart |-> !commitActive);

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       writeLock,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpCmd_t     cmd,
  output logic       sdaDrvLow,
  output logic       busy
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;
  logic       sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;

  busState_e  state, nextState;
  logic [3:0] bitCnt;
  logic       ackDrive, txEn, armed, masterAck;
  logic [CNT_W-1:0] busyCnt;
  logic       selMatch, commitNow, quiet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], scl};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;

  assign busy      = (busyCnt != '0);
  assign selMatch  = (rxByte[7:4] == SELECT_PREFIX) && (rxByte[3:1] == chipSel);
  assign commitNow = !busy && stopDet && (state == ST_WRITE) && (bitCnt == 4'd1) && armed;
  assign quiet     = busy || startDet || stopDet;

  always_comb begin
    cmd             = '0;
    cmd.rxBit       = sdaS;
    cmd.commitStart = commitNow;
    if (!quiet && state != ST_IDLE) begin
      if (sclRise && bitCnt < 4'd8 && state != ST_READ) cmd.shiftIn = 1'b1;
      if (sclRise && state == ST_READ && bitCnt == 4'd8 && !sdaS) cmd.incAddr = 1'b1;
      if (sclFall && bitCnt == 4'd8) begin
        case (state)
          ST_ADDR_HI: cmd.loadAddrHi = 1'b1;
          ST_ADDR_LO: cmd.loadAddrLo = 1'b1;
          ST_WRITE:   cmd.latchData  = !writeLock;
          default:    ;
        endcase
      end
      if (sclFall && state == ST_READ && bitCnt >= 4'd1 && bitCnt <= 4'd7) cmd.shiftTx = 1'b1;
      if (sclFall && bitCnt == 4'd9 &&
          ((state == ST_SELECT && nextState == ST_READ) || (state == ST_READ && masterAck)))
        cmd.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nextState <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txEn      <= 1'b0;
      armed     <= 1'b0;
      masterAck <= 1'b0;
      busyCnt   <= '0;
    end else if (busy) begin
      busyCnt  <= busyCnt - CNT_ONE;
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      armed    <= 1'b0;
    end else if (commitNow) begin
      busyCnt  <= CNT_LOAD;
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      armed    <= 1'b0;
    end else if (startDet) begin
      state    <= ST_SELECT;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      armed    <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      armed    <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          bitCnt <= bitCnt + 4'd1;
        end else if (bitCnt == 4'd8) begin
          bitCnt    <= 4'd9;
          masterAck <= !sdaS;
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          case (state)
            ST_READ: txEn <= 1'b0;
            ST_SELECT: begin
              if (selMatch) begin
                ackDrive  <= 1'b1;
                nextState <= rxByte[0] ? ST_READ : ST_ADDR_HI;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR_HI: begin
              ackDrive  <= 1'b1;
              nextState <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
              ackDrive  <= 1'b1;
              nextState <= ST_WRITE;
            end
            ST_WRITE: begin
              if (!writeLock) begin
                ackDrive  <= 1'b1;
                armed     <= 1'b1;
                nextState <= ST_WRITE;
              end else begin
                state <= ST_IDLE;
                armed <= 1'b0;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end else if (bitCnt == 4'd9) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (state == ST_READ) begin
            if (masterAck) txEn  <= 1'b1;
            else           state <= ST_IDLE;
          end else begin
            state <= nextState;
            if (nextState == ST_READ) txEn <= 1'b1;
          end
        end
      end
    end
  end

  assign sdaDrvLow = ackDrive | (txEn & ~txBit);

  // no drive on the bus while the array is being written
  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!ackDrive && !txEn));

  // a write cycle is only ever opened by a STOP seen in the data phase
  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet && state == ST_WRITE));

  // a locked data byte is never acknowledged
  assert_lock_no_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!quiet && state == ST_WRITE && writeLock && sclFall && bitCnt == 4'd8) |=> !ackDrive);

  // the master's acknowledge slot after a read byte is left free
  assert_release_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && bitCnt == 4'd9) |-> !txEn);

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       writeLock,
  output logic       sdaDrvLow,
  output logic       busy
);

  dpCmd_t     cmd;
  logic [7:0] rxByte;
  logic       txBit;

  eeprom_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaIn),
    .chipSel   (chipSel),
    .writeLock (writeLock),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .cmd       (cmd),
    .sdaDrvLow (sdaDrvLow),
    .busy      (busy)
  );

  eeprom_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

endmodule

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;

  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 64;
  localparam int WCYC   = 400;
  localparam int HALF   = 10;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, scl, msda, writeLock;
  logic [2:0] chipSel;
  logic sdaDrvLow, busy, sdaBus;
  assign sdaBus = msda & ~sdaDrvLow;

  eeprom_i2c_slave #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus), .chipSel(chipSel),
    .writeLock(writeLock), .sdaDrvLow(sdaDrvLow), .busy(busy));

  int refMem [DEPTH];
  int checks = 0, errors = 0;
  int runLen = 0, lastPulse = 0, quietViol = 0;
  bit done = 0;

  // per-clock model observations of the write cycle
  always @(negedge clk) begin
    if (busy) begin
      runLen++;
      if (sdaDrvLow) quietViol++;
    end else if (runLen != 0) begin
      lastPulse = runLen;
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    msda = 1'b1; ticks(HALF);
    scl = 1'b1;  ticks(HALF);
    msda = 1'b0; ticks(HALF);
    scl = 1'b0;  ticks(4);
  endtask

  task automatic stopCond();
    msda = 1'b0; ticks(HALF);
    scl = 1'b1;  ticks(HALF);
    msda = 1'b1; ticks(HALF);
  endtask

  task automatic sendBit(input logic b);
    msda = b;   ticks(HALF);
    scl = 1'b1; ticks(HALF);
    scl = 1'b0; ticks(4);
  endtask

  task automatic recvBit(output logic b);
    msda = 1'b1; ticks(HALF);
    scl = 1'b1;  ticks(HALF / 2);
    b = sdaBus;  ticks(HALF / 2);
    scl = 1'b0;  ticks(4);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(!giveAck);
  endtask

  function automatic logic [7:0] selByte(input logic rw);
    return {4'b1010, CS, rw};
  endfunction

  task automatic sendAddr(input int addr, input string tag);
    bit ack;
    sendByte(selByte(1'b0), ack); check(ack, {tag, " select ack"}, ack, 1);
    sendByte(8'((addr >> 8) & 8'hFF), ack); check(ack, {tag, " addr hi ack"}, ack, 1);
    sendByte(8'(addr & 8'hFF), ack); check(ack, {tag, " addr lo ack"}, ack, 1);
  endtask

  task automatic writeBytes(input int addr, input logic [7:0] d[$], input string tag);
    bit ack;
    int okAll = 1;
    startCond();
    sendAddr(addr, tag);
    foreach (d[i]) begin
      sendByte(d[i], ack);
      if (ack != !writeLock) okAll = 0;
    end
    check(okAll == 1, {tag, " data acks"}, okAll, 1);
    stopCond();
    if (!writeLock)
      foreach (d[i])
        refMem[(addr & ~(PAGE - 1)) | ((addr + i) & (PAGE - 1))] = d[i];
  endtask

  task automatic waitWriteDone();
    bit ack = 0;
    ticks(2);
    check(busy == 1'b1, "R6 busy after commit", busy, 1);
    startCond(); sendByte(selByte(1'b0), ack); stopCond();
    check(!ack, "R6 poll nack while busy", ack, 0);
    for (int n = 0; n < 20 && !ack; n++) begin
      startCond(); sendByte(selByte(1'b0), ack); stopCond();
    end
    check(ack, "R6 poll ack after cycle", ack, 1);
    check(busy == 1'b0, "R6 busy low at ack", busy, 0);
    check(lastPulse == WCYC, "R6 busy length", lastPulse, WCYC);
  endtask

  task automatic randomRead(input int addr, input int n, output logic [7:0] q[$], input string tag);
    bit ack;
    logic [7:0] d;
    q = {};
    startCond();
    sendAddr(addr, tag);
    startCond();
    sendByte(selByte(1'b1), ack); check(ack, {tag, " read select ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, d);
      q.push_back(d);
    end
    stopCond();
  endtask

  initial begin
    logic [7:0] q[$];
    logic [7:0] d;
    bit ack;
    int bad;
    for (int i = 0; i < DEPTH; i++) refMem[i] = -1;
    rstN = 1'b0; scl = 1'b1; msda = 1'b1; writeLock = 1'b0; chipSel = CS;
    ticks(5);
    check(busy == 1'b0, "R1 busy at reset", busy, 0);
    check(sdaDrvLow == 1'b0, "R1 sda released at reset", sdaDrvLow, 0);
    rstN = 1'b1;
    ticks(5);

    // R3 byte write then R7 random read
    writeBytes(11'h123, '{8'hA5}, "R3");
    waitWriteDone();
    randomRead(11'h123, 1, q, "R7");
    check(q[0] == 8'hA5, "R3 R7 byte readback", q[0], 8'hA5);

    // R2 select mismatch on pins and on prefix
    startCond();
    sendByte({4'b1010, 3'b100, 1'b0}, ack);
    check(!ack, "R2 wrong pins nack", ack, 0);
    sendByte(8'h00, ack);
    check(!ack, "R2 ignored until start", ack, 0);
    stopCond();
    startCond();
    sendByte({4'b1011, CS, 1'b0}, ack);
    check(!ack, "R2 wrong prefix nack", ack, 0);
    stopCond();
    check(busy == 1'b0, "R2 no cycle after mismatch", busy, 0);

    // R4 full page, then partial page write that wraps
    q = {};
    for (int i = 0; i < PAGE; i++) q.push_back(8'((i * 3 + 7) & 8'hFF));
    writeBytes(11'h040, q, "R4 full");
    waitWriteDone();
    writeBytes(11'h07E, '{8'h11, 8'h12, 8'h13, 8'h14}, "R4 wrap");
    waitWriteDone();
    randomRead(11'h040, PAGE, q, "R8 page");
    bad = 0;
    for (int i = 0; i < PAGE; i++)
      if (int'(q[i]) != refMem[11'h040 + i]) begin
        bad++;
        check(0, "R4 R8 page byte", q[i], refMem[11'h040 + i]);
      end
    check(bad == 0, "R4 page contents", bad, 0);
    check(q[0] == 8'h13 && q[63] == 8'h12 && q[1] == 8'h14, "R4 wrapped bytes", q[0], 8'h13);

    // R8 wrap from top address to 0
    writeBytes(11'h7FF, '{8'h5C}, "R8 top");
    waitWriteDone();
    writeBytes(11'h000, '{8'hC3}, "R8 zero");
    waitWriteDone();
    randomRead(11'h7FF, 2, q, "R8 wrap");
    check(q[0] == 8'h5C, "R8 top byte", q[0], 8'h5C);
    check(q[1] == 8'hC3, "R8 wrap to zero", q[1], 8'hC3);

    // R9 nack ends output, address holds
    check(sdaDrvLow == 1'b0, "R9 sda released after nack", sdaDrvLow, 0);
    startCond();
    sendByte(selByte(1'b1), ack); check(ack, "R9 current select ack", ack, 1);
    recvByte(1'b0, d);
    stopCond();
    check(d == 8'hC3, "R9 current read repeats", d, 8'hC3);

    // R5 stop inside a data byte, and stop after address only
    startCond();
    sendAddr(11'h123, "R5 mid");
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    stopCond();
    ticks(3);
    check(busy == 1'b0, "R5 no cycle mid byte", busy, 0);
    startCond();
    sendAddr(11'h123, "R5 addr only");
    stopCond();
    ticks(3);
    check(busy == 1'b0, "R5 no cycle addr only", busy, 0);
    randomRead(11'h123, 1, q, "R5 read");
    check(q[0] == 8'hA5, "R5 memory unchanged", q[0], 8'hA5);

    // R10 write lock
    writeLock = 1'b1;
    writeBytes(11'h123, '{8'h77}, "R10");
    ticks(3);
    check(busy == 1'b0, "R10 no cycle when locked", busy, 0);
    randomRead(11'h123, 1, q, "R10 read");
    check(q[0] == 8'hA5, "R10 locked read", q[0], 8'hA5);
    writeLock = 1'b0;

    check(quietViol == 0, "R6 bus quiet while busy", quietViol, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule